// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block collects eight interrupt request lines for an 8-bit processor that takes interrupts through an acknowledge handshake. Any request line seen high is latched as pending. A priority walk then picks the best pending level that is not shadowed by a level already in service, and the block raises its interrupt output to the processor.

The processor answers with three acknowledge pulses. On these pulses the block places a three-byte subroutine call on the data bus: first the call opcode, then the low byte of the handler address, then the high byte. The handler address is a programmable 16-bit base plus four times the level number.

The level taken on the first pulse moves from pending to in service. An end-of-interrupt strobe retires the best-ranked level in service. Priority is either fixed, with line 0 first, or rotating, where each retired level drops to the bottom of the order.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `int_out` and `dbus_oe` are low, nothing is pending or in service, the base is 0x0000, and priority is fixed.
- R2: A request line sampled high for a single clock sets its pending bit. The bit stays set after the line returns low. `int_out` rises in the cycle after the sampling edge when that level is eligible.
- R3: In fixed mode line 0 has the highest priority and line 7 the lowest. The block selects the eligible pending level with the best rank.
- R4: A pending level is eligible only when no level of equal or higher rank is in service. A better-ranked request arriving while a lower one is in service is therefore taken, which gives nesting.
- R5: At the rising edge of the first acknowledge pulse of a sequence, the byte latched for the bus is 0xCD.
- R6: The rising edges of the second and third pulses latch bits 7:0 and then bits 15:8 of (base + 4 × level), where level is the one fixed on the first pulse.
- R7: `dbus_oe` equals `inta` delayed by one clock, and `dbus_out` holds the byte latched at the most recent rising edge of `inta`.
- R8: On the first pulse, the selected level's pending bit clears, its in-service bit sets, and `int_out` stays low until the third pulse has been seen.
- R9: An `eoi` strobe clears only the best-ranked in-service bit. With nothing in service it has no effect.
- R10: In rotating mode an `eoi` makes the retired level the lowest rank. The levels after it, in circular order, take the top ranks. The order out of reset is 0 first.
- R11: Configuration writes take effect from the next cycle. Address 0 sets base bits 7:0, address 1 sets base bits 15:8, and address 2 bit 0 selects rotating (1) or fixed (0) priority. The mode may change at any time.
- R12: If nothing is eligible at the first pulse, the sequence still runs with level 7's address, and the pending and in-service state are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Request lines, active high |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse from the processor, active high |
| dbus_out | output | 8 | Byte presented during acknowledge |
| dbus_oe | output | 1 | Data bus drive enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_data | input | 8 | Configuration write data |
| eoi | input | 1 | End-of-interrupt strobe |

## Verification
The bench raises several requests together (lines 3, 5 and 6) so that the chosen level shows whether the fixed rank order is honoured. A better-ranked line 1 is then injected while line 3 is in service, which separates correct nesting from plain lowest-index selection. Each end-of-interrupt is followed by a check of `int_out`: if the wrong in-service bit were retired, a shadowed request would be released early. Rotating runs send the same request pair (0 and 7) as the later fixed run, so the two modes must pick different levels. Spurious acknowledges, empty end-of-interrupts and a change of base tell the fallback address and the ignored strobes apart from normal service.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_IRQ = 8,
  parameter logic [7:0] CALL_OP = 8'hCD,
  parameter int VEC_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  output logic             int_out,
  input  logic             inta,
  output logic [7:0]       dbus_out,
  output logic             dbus_oe,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [7:0]       cfg_data,
  input  logic             eoi
);
  localparam int LW = $clog2(N_IRQ);

  logic [N_IRQ-1:0] irr, isr, set_m, clr_m;
  logic [15:0]      base, vaddr;
  logic             rotate, inta_q, sel_vld, eoi_vld;
  logic [LW-1:0]    lowest, pbase, sel_lvl, eoi_lvl, cur_lvl;
  logic [1:0]       phase;
  int               blk;

  wire ack_rise  = inta & ~inta_q;
  wire ack_start = ack_rise && (phase == 2'd0);

  assign pbase   = rotate ? LW'(lowest + 1'b1) : '0;
  assign vaddr   = base + (16'(cur_lvl) << VEC_SHIFT);
  assign int_out = sel_vld && (phase == 2'd0);

  always_comb begin
    blk = N_IRQ; eoi_lvl = '0; eoi_vld = 1'b0;
    sel_lvl = '0; sel_vld = 1'b0;
    for (int k = N_IRQ - 1; k >= 0; k--) begin
      if (isr[LW'(int'(pbase) + k)]) begin
        blk = k; eoi_lvl = LW'(int'(pbase) + k); eoi_vld = 1'b1;
      end
    end
    for (int k = N_IRQ - 1; k >= 0; k--) begin
      if (irr[LW'(int'(pbase) + k)] && k < blk) begin
        sel_lvl = LW'(int'(pbase) + k); sel_vld = 1'b1;
      end
    end
  end

  always_comb begin
    set_m = '0; clr_m = '0;
    if (ack_start && sel_vld) set_m[sel_lvl] = 1'b1;
    if (eoi && eoi_vld) clr_m[eoi_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0; isr <= '0; base <= '0; rotate <= 1'b0;
      lowest <= '1; inta_q <= 1'b0; phase <= 2'd0;
      cur_lvl <= '0; dbus_out <= '0; dbus_oe <= 1'b0;
    end else begin
      inta_q  <= inta;
      dbus_oe <= inta;
      irr <= (irr | irq_in) & ~set_m;
      isr <= (isr & ~clr_m) | set_m;
      if (eoi && eoi_vld && rotate) lowest <= eoi_lvl;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0:    base[7:0]  <= cfg_data;
          2'd1:    base[15:8] <= cfg_data;
          2'd2:    rotate     <= cfg_data[0];
          default: ;
        endcase
      end
      if (ack_rise) begin
        case (phase)
          2'd0: begin
            dbus_out <= CALL_OP;
            cur_lvl  <= sel_vld ? sel_lvl : '1;
            phase    <= 2'd1;
          end
          2'd1: begin
            dbus_out <= vaddr[7:0];
            phase    <= 2'd2;
          end
          default: begin
            dbus_out <= vaddr[15:8];
            phase    <= 2'd0;
          end
        endcase
      end
    end
  end

  assert_call_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |=> (dbus_oe && dbus_out == CALL_OP));

  assert_int_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |=> !int_out);

  assert_one_new_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr & ~$past(isr)));

  assert_sel_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr[sel_lvl] && !isr[sel_lvl]));

  assert_isr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi |=> ((isr & $past(isr)) == $past(isr)));

  assert_eoi_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && (|isr) && !ack_start) |=> ($countones(isr) == $countones($past(isr)) - 1));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, inta = 1'b0, cfg_we = 1'b0, eoi = 1'b0;
  logic [7:0] irq_in = '0, cfg_data = '0;
  logic [1:0] cfg_addr = '0;
  logic int_out, dbus_oe;
  logic [7:0] dbus_out;

  irq_vector_ctrl dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_out(int_out),
    .inta(inta), .dbus_out(dbus_out), .dbus_oe(dbus_oe), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .eoi(eoi));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";
  bit done = 0;

  bit m_irr[8], m_isr[8];
  int m_low = 7, m_rot = 0, m_base = 0, m_phase = 0, m_lvl = 0, m_dout = 0;
  bit m_q = 0, m_oe = 0;

  function automatic int top_rank();
    return m_rot ? (m_low + 1) % 8 : 0;
  endfunction
  function automatic int pick_sel();
    for (int k = 0; k < 8; k++) begin
      int l = (top_rank() + k) % 8;
      if (m_isr[l]) return -1;
      if (m_irr[l]) return l;
    end
    return -1;
  endfunction
  function automatic int pick_eoi();
    for (int k = 0; k < 8; k++) begin
      int l = (top_rank() + k) % 8;
      if (m_isr[l]) return l;
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    int s, e, addr;
    bit rise;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_irr[i] = 0; m_isr[i] = 0; end
      m_low = 7; m_rot = 0; m_base = 0; m_phase = 0; m_lvl = 0; m_dout = 0; m_q = 0; m_oe = 0;
    end else begin
      s = pick_sel(); e = pick_eoi(); rise = inta && !m_q;
      addr = (m_base + m_lvl * 4) & 16'hFFFF;
      for (int i = 0; i < 8; i++) if (irq_in[i]) m_irr[i] = 1;
      if (eoi && e >= 0) begin m_isr[e] = 0; if (m_rot != 0) m_low = e; end
      if (rise) begin
        if (m_phase == 0) begin
          m_dout = 8'hCD;
          if (s >= 0) begin m_irr[s] = 0; m_isr[s] = 1; m_lvl = s; end
          else m_lvl = 7;
          m_phase = 1;
        end else if (m_phase == 1) begin
          m_dout = addr & 8'hFF; m_phase = 2;
        end else begin
          m_dout = (addr >> 8) & 8'hFF; m_phase = 0;
        end
      end
      if (cfg_we) begin
        if (cfg_addr == 0) m_base = (m_base & 16'hFF00) | cfg_data;
        else if (cfg_addr == 1) m_base = (m_base & 16'h00FF) | (int'(cfg_data) << 8);
        else if (cfg_addr == 2) m_rot = cfg_data[0];
      end
      m_oe = inta; m_q = inta;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    bit m_int;
    m_int = (m_phase == 0) && (pick_sel() >= 0);
    chk(int_out === m_int, tag, "int_out", int_out, m_int);
    chk(dbus_oe === m_oe, "R7", "dbus_oe", dbus_oe, m_oe);
    if (m_oe) chk(dbus_out === m_dout[7:0], tag, "dbus_out", dbus_out, m_dout);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(input int n = 1); repeat (n) @(negedge clk); endtask
  task automatic cfg(input int a, input int d);
    cfg_we = 1; cfg_addr = a[1:0]; cfg_data = d[7:0]; tick(); cfg_we = 0;
  endtask
  task automatic req(input int mask); irq_in = mask[7:0]; tick(); irq_in = '0; endtask
  task automatic do_eoi(); eoi = 1; tick(); eoi = 0; tick(); endtask
  task automatic ack(output int b0, output int b1, output int b2);
    int b[3];
    for (int p = 0; p < 3; p++) begin
      inta = 1; tick();
      chk(dbus_oe === 1'b1, "R7", "oe in pulse", dbus_oe, 1);
      b[p] = dbus_out;
      tick(); inta = 0; tick(2);
    end
    b0 = b[0]; b1 = b[1]; b2 = b[2];
  endtask
  task automatic expect_vec(input string req, input int lo, input int hi);
    int b0, b1, b2;
    ack(b0, b1, b2);
    chk(b0 == 8'hCD, "R5", "byte0", b0, 8'hCD);
    chk(b1 == lo, req, "byte1", b1, lo);
    chk(b2 == hi, req, "byte2", b2, hi);
  endtask

  initial begin
    tick(3);
    chk(int_out === 1'b0, "R1", "int_out", int_out, 0);
    chk(dbus_oe === 1'b0, "R1", "dbus_oe", dbus_oe, 0);
    rst_n = 1; tick();
    tag = "R11"; cfg(0, 8'h40); cfg(1, 8'h12);

    tag = "R2"; req(8'h20);
    chk(int_out === 1'b1, "R2", "int after req", int_out, 1);
    tick(3);
    chk(int_out === 1'b1, "R2", "int held", int_out, 1);

    tag = "R3"; req(8'h48);
    expect_vec("R6", 8'h4C, 8'h12);
    chk(int_out === 1'b0, "R4", "lower blocked", int_out, 0);
    tag = "R4"; req(8'h02);
    chk(int_out === 1'b1, "R4", "nested int", int_out, 1);
    expect_vec("R4", 8'h44, 8'h12);
    tag = "R9"; do_eoi();
    chk(int_out === 1'b0, "R9", "only best isr cleared", int_out, 0);
    do_eoi();
    chk(int_out === 1'b1, "R9", "int after 2nd eoi", int_out, 1);
    tag = "R8"; expect_vec("R3", 8'h54, 8'h12); do_eoi();
    expect_vec("R3", 8'h58, 8'h12); do_eoi();
    chk(int_out === 1'b0, "R8", "all served", int_out, 0);

    tag = "R12"; expect_vec("R12", 8'h5C, 8'h12);
    chk(int_out === 1'b0, "R12", "no state change", int_out, 0);
    tag = "R9"; do_eoi();
    chk(int_out === 1'b0, "R9", "empty eoi", int_out, 0);
    req(8'h04); expect_vec("R9", 8'h48, 8'h12); do_eoi();

    tag = "R10"; cfg(2, 1); req(8'h03);
    expect_vec("R10", 8'h40, 8'h12); do_eoi();
    req(8'h01);
    expect_vec("R10", 8'h44, 8'h12); do_eoi();
    req(8'h80);
    expect_vec("R10", 8'h5C, 8'h12); do_eoi();
    expect_vec("R10", 8'h40, 8'h12); do_eoi();

    tag = "R11"; cfg(2, 0); req(8'h81);
    expect_vec("R11", 8'h40, 8'h12); do_eoi();
    expect_vec("R11", 8'h5C, 8'h12); do_eoi();
    cfg(0, 8'h80); req(8'h10);
    expect_vec("R11", 8'h90, 8'h12); do_eoi();
    tick(3);
    chk(dbus_oe === 1'b0, "R7", "idle bus", dbus_oe, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule